// File: doc/BRIEF.md
# Credit-Gated Flit Injection Queue

This block sits between a traffic endpoint and one input port of a network router. The endpoint hands over flits through a valid/ready handshake. The block holds them in a first-in, first-out store and sends them to the router in arrival order.

The router side has no ready signal. Instead, the block keeps a credit counter that mirrors the free slots in the router's input buffer. After reset, the counter starts at the size of that buffer. Each flit sent spends one credit, and each credit pulse from the router gives one back. While the counter is zero, nothing leaves the queue, so the router's buffer cannot overflow.

The block is meant to be placed once per endpoint injection channel. Its parameters are the flit width, the queue depth and the downstream buffer size.

Top module: `flit_inject_queue`

## Requirements
- R1: After reset, `src_ready` is 1 and `rtr_valid` is 0.
- R2: `src_ready` is 0 exactly when the queue holds `DEPTH` flits. A flit offered while `src_ready` is 0 is not taken, even if a flit leaves in the same cycle.
- R3: Flits leave on `rtr_flit` in the order in which they were accepted. `rtr_flit` carries the oldest held flit whenever `rtr_valid` is 1.
- R4: `rtr_valid` is 1 exactly when the queue is non-empty and the credit count is above zero. Every cycle with `rtr_valid` at 1 is one flit sent, and it spends one credit. The number of flits in the router's buffer never exceeds `INIT_CREDITS`.
- R5: A cycle with `crd_return` at 1 adds one credit. A cycle that both sends a flit and receives a credit leaves the count unchanged.
- R6: Reset loads the credit count with `INIT_CREDITS`. With no credits returned, exactly `INIT_CREDITS` flits are sent.
- R7: A credit that arrives while the count already equals `INIT_CREDITS` and no flit is sent is dropped. The count never rises above `INIT_CREDITS`.
- R8: A flit accepted in cycle t can be sent no earlier than cycle t+1. There is no bypass from `src_flit` to `rtr_flit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Endpoint offers a flit |
| src_flit | input | FLIT_W | Flit offered by the endpoint |
| src_ready | output | 1 | Queue can take a flit this cycle |
| rtr_valid | output | 1 | A flit is sent to the router this cycle |
| rtr_flit | output | FLIT_W | Flit sent to the router |
| crd_return | input | 1 | One credit returned by the router this cycle |

## Verification
The hardest state to reach from the ports is a credit arriving while the counter is already at its ceiling. A well-behaved router never returns more credits than it was given. The bench therefore first drains the queue completely with returns enabled, so the count climbs back to `INIT_CREDITS`. It then injects extra credit pulses while nothing is queued. After that, it fills the queue with no returns and counts the flits that leave; only `INIT_CREDITS` must go out. Long random phases with an emulated router buffer also produce cycles where a flit is sent and a credit arrives together, and cycles where the queue is full and credits are zero at the same time.

// File: rtl/flitq_pkg.sv
package flitq_pkg;

    typedef enum logic [1:0] {
        CR_HOLD  = 2'd0,
        CR_SPEND = 2'd1,
        CR_GAIN  = 2'd2
    } cr_act_e;

    // Net effect of one cycle on the credit counter
    function automatic cr_act_e cr_classify(input logic spend,
                                            input logic gain,
                                            input logic at_ceiling);
        if (spend && !gain)
            return CR_SPEND;
        if (gain && !spend && !at_ceiling)
            return CR_GAIN;
        return CR_HOLD;
    endfunction

endpackage

// File: rtl/flitq_credit.sv
module flitq_credit
    import flitq_pkg::*;
#(
    parameter int INIT_CREDITS = 4,
    parameter int CW           = $clog2(INIT_CREDITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spend,
    input  logic          gain,
    output logic [CW-1:0] level,
    output logic          has_credit
);

    localparam logic [CW-1:0] CEIL = CW'(INIT_CREDITS);

    typedef struct packed {
        logic [CW-1:0] level;
    } cr_state_t;

    cr_state_t s_d, s_q;
    cr_act_e   act;

    always_comb begin
        s_d = s_q;
        act = cr_classify(spend && (s_q.level != '0), gain, s_q.level == CEIL);
        unique case (act)
            CR_SPEND: s_d.level = s_q.level - 1'b1;
            CR_GAIN:  s_d.level = s_q.level + 1'b1;
            default:  s_d.level = s_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '{level: CEIL};
        else
            s_q <= s_d;
    end

    assign level      = s_q.level;
    assign has_credit = (s_q.level != '0);

endmodule

// File: rtl/flitq_store.sv
module flitq_store #(
    parameter int FLIT_W = 32,
    parameter int DEPTH  = 8,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNTW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [FLIT_W-1:0] push_data,
    input  logic              pop,
    output logic [FLIT_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    output logic [CNTW-1:0]   fill
);

    localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CAP  = CNTW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]   wr_ptr;
        logic [AW-1:0]   rd_ptr;
        logic [CNTW-1:0] fill;
    } st_state_t;

    st_state_t s_d, s_q;
    logic      push_ok, pop_ok;

    logic [FLIT_W-1:0] slot_q [DEPTH];

    always_comb begin
        s_d     = s_q;
        push_ok = push && (s_q.fill != CAP);
        pop_ok  = pop && (s_q.fill != '0);
        if (push_ok)
            s_d.wr_ptr = (s_q.wr_ptr == LAST) ? '0 : s_q.wr_ptr + 1'b1;
        if (pop_ok)
            s_d.rd_ptr = (s_q.rd_ptr == LAST) ? '0 : s_q.rd_ptr + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   s_d.fill = s_q.fill + 1'b1;
            2'b01:   s_d.fill = s_q.fill - 1'b1;
            default: s_d.fill = s_q.fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && (s_q.wr_ptr == AW'(i)))
                slot_q[i] <= push_data;
        end
    end

    assign head_data = slot_q[s_q.rd_ptr];
    assign full      = (s_q.fill == CAP);
    assign empty     = (s_q.fill == '0);
    assign fill      = s_q.fill;

endmodule

// File: rtl/flit_inject_queue.sv
module flit_inject_queue #(
    parameter int FLIT_W       = 32,
    parameter int DEPTH        = 8,
    parameter int INIT_CREDITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [FLIT_W-1:0] src_flit,
    output logic              src_ready,
    output logic              rtr_valid,
    output logic [FLIT_W-1:0] rtr_flit,
    input  logic              crd_return
);

    localparam int CW   = $clog2(INIT_CREDITS + 1);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            q_full, q_empty, has_credit, take, send;
    logic [CW-1:0]   cred_level;
    logic [CNTW-1:0] fill_level;

    assign take = src_valid && !q_full;
    assign send = !q_empty && has_credit;

    flitq_store #(
        .FLIT_W (FLIT_W),
        .DEPTH  (DEPTH),
        .CNTW   (CNTW)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_data (src_flit),
        .pop       (send),
        .head_data (rtr_flit),
        .full      (q_full),
        .empty     (q_empty),
        .fill      (fill_level)
    );

    flitq_credit #(
        .INIT_CREDITS (INIT_CREDITS),
        .CW           (CW)
    ) credit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .spend      (send),
        .gain       (crd_return),
        .level      (cred_level),
        .has_credit (has_credit)
    );

    assign src_ready = !q_full;
    assign rtr_valid = send;

endmodule

// File: rtl/flitq_checker.sv
module flitq_checker #(
    parameter int DEPTH        = 8,
    parameter int INIT_CREDITS = 4,
    parameter int CW           = $clog2(INIT_CREDITS + 1),
    parameter int CNTW         = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            src_valid,
    input logic            src_ready,
    input logic            rtr_valid,
    input logic            crd_return,
    input logic [CW-1:0]   credits,
    input logic [CNTW-1:0] fill
);

    localparam logic [CW-1:0]   CEIL = CW'(INIT_CREDITS);
    localparam logic [CNTW-1:0] CAP  = CNTW'(DEPTH);

    // R2
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CAP) |-> !src_ready);

    // R4
    no_send_dry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtr_valid |-> (credits != '0));

    // R4
    no_send_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !rtr_valid);

    // R4
    spend_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtr_valid && !crd_return) |=> (credits == $past(credits) - 1'b1));

    // R5
    gain_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crd_return && !rtr_valid && (credits != CEIL)) |=> (credits == $past(credits) + 1'b1));

    // R5
    net_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crd_return && rtr_valid) |=> $stable(credits));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        credits <= CEIL);

    // R8
    accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && !rtr_valid) |=> (fill == $past(fill) + 1'b1));

endmodule

bind flit_inject_queue flitq_checker #(
    .DEPTH        (DEPTH),
    .INIT_CREDITS (INIT_CREDITS),
    .CW           (CW),
    .CNTW         (CNTW)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_valid  (src_valid),
    .src_ready  (src_ready),
    .rtr_valid  (rtr_valid),
    .crd_return (crd_return),
    .credits    (cred_level),
    .fill       (fill_level)
);

// File: tb/flit_inject_queue_tb_top.sv
module flit_inject_queue_tb_top;

    localparam int FW   = 16;
    localparam int DEP  = 4;
    localparam int INIT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_valid = 1'b0;
    logic [FW-1:0] src_flit = '0;
    logic          src_ready;
    logic          rtr_valid;
    logic [FW-1:0] rtr_flit;
    logic          crd_return = 1'b0;

    always #4 clk = ~clk;

    flit_inject_queue #(
        .FLIT_W       (FW),
        .DEPTH        (DEP),
        .INIT_CREDITS (INIT)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (src_valid),
        .src_flit   (src_flit),
        .src_ready  (src_ready),
        .rtr_valid  (rtr_valid),
        .rtr_flit   (rtr_flit),
        .crd_return (crd_return)
    );

    logic [FW-1:0] mq[$];
    int n_cmp = 0, n_bad = 0;
    int cr = INIT;
    int down_occ = 0;
    int n_sent = 0;
    int next_val = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int p_src, input int p_drn, input bit spur);
        bit exp_v, exp_r, send, enq, ret;
        @(negedge clk);
        exp_r = (mq.size() < DEP);
        exp_v = (mq.size() > 0) && (cr > 0);
        chk(src_ready == exp_r, "R2", int'(src_ready), int'(exp_r));
        chk(rtr_valid == exp_v, "R4 R5", int'(rtr_valid), int'(exp_v));
        if (exp_v && rtr_valid)
            chk(rtr_flit == mq[0], "R3", int'(rtr_flit), int'(mq[0]));
        chk(down_occ <= INIT, "R4 occupancy", down_occ, INIT);
        src_valid = (($urandom % 100) < p_src);
        src_flit  = FW'(next_val);
        ret = 1'b0;
        if (down_occ > 0 && (($urandom % 100) < p_drn)) begin
            ret = 1'b1;
            down_occ--;
        end
        if (spur) ret = 1'b1;
        crd_return = ret;
        send = exp_v;
        enq  = src_valid && exp_r;
        if (send) begin
            void'(mq.pop_front());
            down_occ++;
            n_sent++;
        end
        if (enq) begin
            mq.push_back(src_flit);
            next_val++;
        end
        cr = cr - int'(send) + int'(ret);
        if (cr > INIT) cr = INIT;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(src_ready == 1'b1, "R1", int'(src_ready), 1);
        chk(rtr_valid == 1'b0, "R1", int'(rtr_valid), 0);

        // R6 initial credit load, R2 fill to full, R8 no bypass
        n_sent = 0;
        repeat (14) step(100, 0, 1'b0);
        chk(n_sent == INIT, "R6", n_sent, INIT);

        // R5 normal traffic with returns
        repeat (400) step(60, 50, 1'b0);

        // drain everything
        repeat (40) step(0, 100, 1'b0);
        chk(cr == INIT && mq.size() == 0, "R5 drained", cr, INIT);

        // R7 spurious returns at ceiling
        repeat (5) step(0, 0, 1'b1);
        n_sent = 0;
        repeat (14) step(100, 0, 1'b0);
        chk(n_sent == INIT, "R7", n_sent, INIT);

        // R8 single flits into an empty queue
        repeat (40) step(0, 100, 1'b0);
        repeat (60) step(15, 100, 1'b0);

        // mixed pressure
        repeat (1500) step(90, 30, 1'b0);
        repeat (1500) step(30, 90, 1'b0);
        repeat (1500) step(70, 70, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule